// File: doc/BRIEF.md
# Sequenced Power-Rail Controller

This block brings up four supply rails for a downstream device array one after another and watches each rail's power-good input. Software drives it through a small byte-wide register port: it sets a single enable bit to start a bring-up, reads a status byte holding the live power-good levels and a latched alarm flag, reads a byte that records which rails faulted, and reads a constant layout identifier.

During bring-up the rails are switched on cumulatively: rail 0 first, and each following rail only once the rail currently being stepped reports good. A rail that stays bad for too long, an external alarm, or a rail that drops out after full bring-up ends in a latched fault with every rail switched off. Clearing the enable bit switches every rail off. A new bring-up is not started until a fixed drain hold-off has elapsed and every power-good input reads low. This keeps fast enable toggling from starting a sequence on rails that are still partly charged. The step timeout and the hold-off are cycle-count parameters, sized by default for about one second and half a second at 100 MHz.

Top module: `pwr_seq_ctrl`

## Requirements
- R1: After reset every rail enable is low. Register 0 reads 0x00, register 2 reads 0x00 and register 3 reads `VERSION` (default 0x03).
- R2: A write to register 0 stores wrData bit 0 as the enable request. Register 0 then reads back that bit in bit 0, with bits 7:1 reading zero.
- R3: Once the enable request is seen while idle, rail 0 is switched on one clock later. Rail k+1 is switched on the clock after railPg[k] is seen high while rail k is the current step. A rail that is switched on stays on until a shutdown, so railEn is always a contiguous run of ones from bit 0.
- R4: Register 1 reads {3'b000, alarm, railPg[3:0]}, with the alarm flag in bit 4. pwrGood is high exactly when that byte equals 0x0F.
- R5: If the current step's power-good stays low for `STEP_TIMEOUT` clocks, the fail register (register 2) gets that rail's bit set (bit i for rail i), the alarm bit is set, and all rails are switched off at the same edge.
- R6: alarmIn sampled high while rails are ramping or fully on sets the alarm bit and switches all rails off. The fail register is not changed.
- R7: After full bring-up, any power-good that drops sets the matching fail bits and the alarm bit, and switches all rails off.
- R8: A write of 0 to register 0 switches all rails off two clocks after the write edge, and clears the fail register and the alarm bit.
- R9: After a shutdown caused by clearing enable, no rail is switched on again until `HOLD_CYCLES` clocks have passed and all power-good inputs read low, even if enable is written back to 1 at once.
- R10: A fault stays latched while enable remains set. Writing 1 again to register 0 does not restart the sequence or clear the fail register.
- R11: Register 3 always reads `VERSION`. Writes to registers 1, 2 and 3 change no register or rail.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Asynchronous active-low reset |
| wrEn | input | 1 | Register write strobe |
| regAddr | input | 2 | Register select: 0 control, 1 status, 2 fail, 3 version |
| wrData | input | 8 | Write data |
| rdData | output | 8 | Combinational read data for regAddr |
| railPg | input | 4 | Per-rail power-good inputs |
| alarmIn | input | 1 | External supply alarm |
| railEn | output | 4 | Per-rail enable outputs |
| pwrGood | output | 1 | All rails good and no alarm |

## Verification
Several properties are checked on every clock. The rail enables always form a prefix mask. A latched alarm always coincides with every rail off. Clearing enable forces the rails off within two clocks. A rail-0 turn-on that follows an earlier power-up is preceded by at least the hold-off period of rails off. The version byte and the link between pwrGood and the status byte are also checked on every clock. Other behaviours only show up under the bench's stimulus from its rail plant model: which rail a timeout blames, the fail mask recorded on a drop-out, fault latching across a repeated enable write, and the fact that rapid on/off toggling does not wedge the controller.

// File: rtl/pwr_seq_pkg.sv
package pwr_seq_pkg;
  localparam int PS_RAILS = 4;
  localparam int PS_IDX_W = (PS_RAILS > 1) ? $clog2(PS_RAILS) : 1;

  localparam logic [1:0] ADDR_CTRL   = 2'd0;
  localparam logic [1:0] ADDR_STATUS = 2'd1;
  localparam logic [1:0] ADDR_FAIL   = 2'd2;
  localparam logic [1:0] ADDR_VER    = 2'd3;

  typedef enum logic [2:0] {
    SEQ_OFF,
    SEQ_RAMP,
    SEQ_ON,
    SEQ_FAULT,
    SEQ_DRAIN
  } seqState_t;

  typedef struct packed {
    logic                stepClr;
    logic                drainClr;
    logic                raiseAlarm;
    logic [PS_RAILS-1:0] failSet;
  } seqStrobe_t;
endpackage

// File: rtl/pwr_seq_dp.sv
module pwr_seq_dp
  import pwr_seq_pkg::*;
#(
  parameter int          STEP_TIMEOUT = 100_000_000,
  parameter int          HOLD_CYCLES  = 50_000_000,
  parameter logic [7:0]  VERSION      = 8'h03
) (
  input  logic                clk,
  input  logic                rstN,
  input  logic                wrEn,
  input  logic [1:0]          regAddr,
  input  logic [7:0]          wrData,
  input  logic [PS_RAILS-1:0] railPg,
  input  seqStrobe_t          strobe,
  output logic                enReq,
  output logic                stepExpired,
  output logic                drainDone,
  output logic                alarm,
  output logic [PS_RAILS-1:0] failMask,
  output logic [7:0]          rdData
);
  localparam int STEP_W = $clog2(STEP_TIMEOUT + 1);
  localparam int HOLD_W = $clog2(HOLD_CYCLES + 1);
  localparam logic [STEP_W-1:0] STEP_LAST = STEP_W'(STEP_TIMEOUT - 1);
  localparam logic [HOLD_W-1:0] HOLD_LAST = HOLD_W'(HOLD_CYCLES - 1);

  logic [STEP_W-1:0] stepCnt;
  logic [HOLD_W-1:0] drainCnt;
  logic [7:0]        statusByte;
  logic [7:0]        ctrlByte;
  logic [7:0]        failByte;

  // enable request register, written only through the control address
  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) enReq <= 1'b0;
    else if (wrEn && regAddr == ADDR_CTRL) enReq <= wrData[0];
  end

  // fault latches: held while enabled, wiped whenever enable is low
  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      failMask <= '0;
      alarm    <= 1'b0;
    end else if (!enReq) begin
      failMask <= '0;
      alarm    <= 1'b0;
    end else begin
      failMask <= failMask | strobe.failSet;
      alarm    <= alarm | strobe.raiseAlarm;
    end
  end

  // per-step watchdog, saturating
  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) stepCnt <= '0;
    else if (strobe.stepClr) stepCnt <= '0;
    else if (!stepExpired) stepCnt <= stepCnt + 1'b1;
  end
  assign stepExpired = (stepCnt == STEP_LAST);

  // drain hold-off, saturating
  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) drainCnt <= '0;
    else if (strobe.drainClr) drainCnt <= '0;
    else if (!drainDone) drainCnt <= drainCnt + 1'b1;
  end
  assign drainDone = (drainCnt == HOLD_LAST);

  always_comb begin
    ctrlByte              = '0;
    ctrlByte[0]           = enReq;
    statusByte            = '0;
    statusByte[PS_RAILS-1:0] = railPg;
    statusByte[PS_RAILS]  = alarm;
    failByte              = '0;
    failByte[PS_RAILS-1:0] = failMask;
  end

  always_comb begin
    unique case (regAddr)
      ADDR_CTRL:   rdData = ctrlByte;
      ADDR_STATUS: rdData = statusByte;
      ADDR_FAIL:   rdData = failByte;
      default:     rdData = VERSION;
    endcase
  end
endmodule

// File: rtl/pwr_seq_fsm.sv
module pwr_seq_fsm
  import pwr_seq_pkg::*;
(
  input  logic                clk,
  input  logic                rstN,
  input  logic                enReq,
  input  logic                alarmIn,
  input  logic [PS_RAILS-1:0] railPg,
  input  logic                stepExpired,
  input  logic                drainDone,
  output seqStrobe_t          strobe,
  output logic [PS_RAILS-1:0] railEn
);
  localparam logic [PS_IDX_W-1:0] IDX_LAST = PS_IDX_W'(PS_RAILS - 1);

  seqState_t            state, stateNxt;
  logic [PS_IDX_W-1:0]  stepIdx, stepIdxNxt;
  logic                 allGood;

  assign allGood = &railPg;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      state   <= SEQ_OFF;
      stepIdx <= '0;
    end else begin
      state   <= stateNxt;
      stepIdx <= stepIdxNxt;
    end
  end

  always_comb begin
    stateNxt   = state;
    stepIdxNxt = stepIdx;
    strobe     = '0;
    unique case (state)
      SEQ_OFF: begin
        if (enReq) begin
          stateNxt       = SEQ_RAMP;
          stepIdxNxt     = '0;
          strobe.stepClr = 1'b1;
        end
      end
      SEQ_RAMP: begin
        if (!enReq) begin
          stateNxt        = SEQ_DRAIN;
          strobe.drainClr = 1'b1;
        end else if (alarmIn) begin
          stateNxt          = SEQ_FAULT;
          strobe.raiseAlarm = 1'b1;
        end else if (railPg[stepIdx]) begin
          strobe.stepClr = 1'b1;
          if (stepIdx == IDX_LAST) stateNxt = SEQ_ON;
          else stepIdxNxt = stepIdx + 1'b1;
        end else if (stepExpired) begin
          stateNxt                = SEQ_FAULT;
          strobe.raiseAlarm       = 1'b1;
          strobe.failSet[stepIdx] = 1'b1;
        end
      end
      SEQ_ON: begin
        if (!enReq) begin
          stateNxt        = SEQ_DRAIN;
          strobe.drainClr = 1'b1;
        end else if (alarmIn) begin
          stateNxt          = SEQ_FAULT;
          strobe.raiseAlarm = 1'b1;
        end else if (!allGood) begin
          stateNxt          = SEQ_FAULT;
          strobe.raiseAlarm = 1'b1;
          strobe.failSet    = ~railPg;
        end
      end
      SEQ_FAULT: begin
        if (!enReq) begin
          stateNxt        = SEQ_DRAIN;
          strobe.drainClr = 1'b1;
        end
      end
      default: begin
        if (drainDone && railPg == '0) stateNxt = SEQ_OFF;
      end
    endcase
  end

  for (genvar i = 0; i < PS_RAILS; i++) begin : g_rail
    assign railEn[i] = (state == SEQ_ON) ||
                       (state == SEQ_RAMP && stepIdx >= PS_IDX_W'(i));
  end
endmodule

// File: rtl/pwr_seq_ctrl.sv
module pwr_seq_ctrl
  import pwr_seq_pkg::*;
#(
  parameter int         STEP_TIMEOUT = 100_000_000,
  parameter int         HOLD_CYCLES  = 50_000_000,
  parameter logic [7:0] VERSION      = 8'h03
) (
  input  logic                clk,
  input  logic                rstN,
  input  logic                wrEn,
  input  logic [1:0]          regAddr,
  input  logic [7:0]          wrData,
  output logic [7:0]          rdData,
  input  logic [PS_RAILS-1:0] railPg,
  input  logic                alarmIn,
  output logic [PS_RAILS-1:0] railEn,
  output logic                pwrGood
);
  seqStrobe_t          strobe;
  logic                enReq;
  logic                stepExpired;
  logic                drainDone;
  logic                alarmQ;
  logic [PS_RAILS-1:0] failMask;

  pwr_seq_dp #(
    .STEP_TIMEOUT(STEP_TIMEOUT),
    .HOLD_CYCLES (HOLD_CYCLES),
    .VERSION     (VERSION)
  ) u_dp (
    .clk        (clk),
    .rstN       (rstN),
    .wrEn       (wrEn),
    .regAddr    (regAddr),
    .wrData     (wrData),
    .railPg     (railPg),
    .strobe     (strobe),
    .enReq      (enReq),
    .stepExpired(stepExpired),
    .drainDone  (drainDone),
    .alarm      (alarmQ),
    .failMask   (failMask),
    .rdData     (rdData)
  );

  pwr_seq_fsm u_fsm (
    .clk        (clk),
    .rstN       (rstN),
    .enReq      (enReq),
    .alarmIn    (alarmIn),
    .railPg     (railPg),
    .stepExpired(stepExpired),
    .drainDone  (drainDone),
    .strobe     (strobe),
    .railEn     (railEn)
  );

  assign pwrGood = (&railPg) && !alarmQ;
endmodule

// File: rtl/pwr_seq_sva.sv
module pwr_seq_sva
  import pwr_seq_pkg::*;
#(
  parameter int         HOLD_CYCLES = 50_000_000,
  parameter logic [7:0] VERSION     = 8'h03
) (
  input logic                clk,
  input logic                rstN,
  input logic                wrEn,
  input logic [1:0]          regAddr,
  input logic [7:0]          wrData,
  input logic [7:0]          rdData,
  input logic [PS_RAILS-1:0] railEn,
  input logic                pwrGood,
  input logic                alarm
);
  localparam int OFF_W = $clog2(HOLD_CYCLES + 2);
  localparam logic [OFF_W-1:0] OFF_MAX = OFF_W'(HOLD_CYCLES + 1);

  logic [OFF_W-1:0] offCnt;
  logic             sawOn;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      offCnt <= '0;
      sawOn  <= 1'b0;
    end else begin
      if (railEn != '0) begin
        offCnt <= '0;
        sawOn  <= 1'b1;
      end else if (offCnt != OFF_MAX) begin
        offCnt <= offCnt + 1'b1;
      end
    end
  end

  // R3: rails switch on as a contiguous run starting at rail 0
  a_r3_prefix_mask: assert property (@(posedge clk) disable iff (!rstN)
    ((railEn & (railEn + {{(PS_RAILS-1){1'b0}}, 1'b1})) == '0));

  // R5, R6, R7, R10: a latched alarm always means every rail is off
  a_r5_alarm_rails_off: assert property (@(posedge clk) disable iff (!rstN)
    alarm |-> (railEn == '0));

  // R8: clearing enable forces the rails off two clocks later
  a_r8_disable_off: assert property (@(posedge clk) disable iff (!rstN)
    (wrEn && regAddr == ADDR_CTRL && !wrData[0]) |=> ##1 (railEn == '0));

  // R9: a restart of rail 0 follows at least the hold-off period of rails off
  a_r9_holdoff: assert property (@(posedge clk) disable iff (!rstN)
    (sawOn && $rose(railEn[0])) |-> (offCnt >= OFF_W'(HOLD_CYCLES)));

  // R11: the identifier byte never changes
  a_r11_version: assert property (@(posedge clk) disable iff (!rstN)
    (regAddr == ADDR_VER) |-> (rdData == VERSION));

  // R4: pwrGood agrees with the status byte being exactly 0x0F
  a_r4_pgood_status: assert property (@(posedge clk) disable iff (!rstN)
    (regAddr == ADDR_STATUS) |-> (pwrGood == (rdData == 8'h0F)));
endmodule

bind pwr_seq_ctrl pwr_seq_sva #(
  .HOLD_CYCLES(HOLD_CYCLES),
  .VERSION    (VERSION)
) u_sva (
  .clk    (clk),
  .rstN   (rstN),
  .wrEn   (wrEn),
  .regAddr(regAddr),
  .wrData (wrData),
  .rdData (rdData),
  .railEn (railEn),
  .pwrGood(pwrGood),
  .alarm  (alarmQ)
);

// File: tb/pwr_seq_ctrl_tb.sv
module pwr_seq_ctrl_tb;
  localparam int T    = 20;
  localparam int H    = 16;
  localparam int UP   = 3;
  localparam int DN   = 5;
  localparam int WDOG = 50000;

  logic       clk = 1'b0;
  logic       rstN = 1'b0;
  logic       wrEn = 1'b0;
  logic [1:0] regAddr = 2'd0;
  logic [7:0] wrData = 8'd0;
  logic [7:0] rdData;
  logic [3:0] railPg = 4'd0;
  logic       alarmIn = 1'b0;
  logic [3:0] railEn;
  logic       pwrGood;

  int checks = 0;
  int failures = 0;
  bit finished = 0;
  int cyc = 0;

  always #5 clk = ~clk;

  pwr_seq_ctrl #(.STEP_TIMEOUT(T), .HOLD_CYCLES(H), .VERSION(8'h03)) u_dut (
    .clk(clk), .rstN(rstN), .wrEn(wrEn), .regAddr(regAddr), .wrData(wrData),
    .rdData(rdData), .railPg(railPg), .alarmIn(alarmIn), .railEn(railEn),
    .pwrGood(pwrGood)
  );

  // ---------------- reference model ----------------
  // states: 0 idle, 1 ramping, 2 all on, 3 faulted, 4 draining
  int   mState = 0;
  int   mIdx = 0;
  int   mStep = 0;
  int   mDrain = 0;
  bit   mEn = 0;
  bit   mAlarm = 0;
  logic [3:0] mFail = 4'd0;

  always @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      mState = 0; mIdx = 0; mStep = 0; mDrain = 0;
      mEn = 0; mAlarm = 0; mFail = 4'd0;
    end else begin
      int nState;
      int nIdx;
      bit stepClr;
      bit drainClr;
      bit raise;
      logic [3:0] fSet;
      nState = mState; nIdx = mIdx; stepClr = 0; drainClr = 0; raise = 0; fSet = 4'd0;
      case (mState)
        0: if (mEn) begin nState = 1; nIdx = 0; stepClr = 1; end
        1: begin
          if (!mEn) begin nState = 4; drainClr = 1; end
          else if (alarmIn) begin nState = 3; raise = 1; end
          else if (railPg[mIdx]) begin
            stepClr = 1;
            if (mIdx == 3) nState = 2; else nIdx = mIdx + 1;
          end else if (mStep == T - 1) begin
            nState = 3; raise = 1; fSet[mIdx] = 1'b1;
          end
        end
        2: begin
          if (!mEn) begin nState = 4; drainClr = 1; end
          else if (alarmIn) begin nState = 3; raise = 1; end
          else if (railPg != 4'hF) begin nState = 3; raise = 1; fSet = ~railPg; end
        end
        3: if (!mEn) begin nState = 4; drainClr = 1; end
        default: if (mDrain == H - 1 && railPg == 4'd0) nState = 0;
      endcase
      if (!mEn) begin mFail = 4'd0; mAlarm = 0; end
      else begin mFail = mFail | fSet; mAlarm = mAlarm | raise; end
      if (stepClr) mStep = 0; else if (mStep != T - 1) mStep++;
      if (drainClr) mDrain = 0; else if (mDrain != H - 1) mDrain++;
      if (wrEn && regAddr == 2'd0) mEn = wrData[0];
      mState = nState; mIdx = nIdx;
    end
  end

  function automatic logic [3:0] expRails();
    logic [3:0] r;
    r = 4'd0;
    if (mState == 2) r = 4'hF;
    else if (mState == 1) for (int i = 0; i < 4; i++) r[i] = (i <= mIdx);
    return r;
  endfunction

  function automatic logic [7:0] expRead(input logic [1:0] a);
    case (a)
      2'd0: return {7'd0, mEn};
      2'd1: return {3'd0, mAlarm, railPg};
      2'd2: return {4'd0, mFail};
      default: return 8'h03;
    endcase
  endfunction

  task automatic chk(input string tag, input logic [7:0] act, input logic [7:0] exp);
    checks++;
    if (act !== exp) begin
      failures++;
      $display("FAIL %s at cycle %0d: actual=0x%02h expected=0x%02h", tag, cyc, act, exp);
    end
  endtask

  // ---------------- rail plant + per-cycle comparison ----------------
  logic [3:0] stuck = 4'd0;
  logic [3:0] dropMask = 4'd0;
  logic [3:0] pgLvl = 4'd0;
  int onCnt[4];
  int offCnt[4];

  initial for (int i = 0; i < 4; i++) begin onCnt[i] = 0; offCnt[i] = 0; end

  always @(negedge clk) begin
    if (rstN && !finished) begin
      string rtag;
      chk("R3 railEn", {4'd0, railEn}, {4'd0, expRails()});
      chk("R4 pwrGood", {7'd0, pwrGood}, {7'd0, (railPg == 4'hF) && !mAlarm});
      case (regAddr)
        2'd0: rtag = "R2 ctrl read";
        2'd1: rtag = "R4 status read";
        2'd2: rtag = "R5 fail read";
        default: rtag = "R11 version read";
      endcase
      chk(rtag, rdData, expRead(regAddr));
    end
    for (int i = 0; i < 4; i++) begin
      if (railEn[i] && !stuck[i]) begin
        offCnt[i] = 0;
        if (onCnt[i] < UP) onCnt[i]++; else pgLvl[i] = 1'b1;
      end else begin
        onCnt[i] = 0;
        if (pgLvl[i]) begin
          if (offCnt[i] < DN) offCnt[i]++; else pgLvl[i] = 1'b0;
        end
      end
    end
    railPg = pgLvl & ~dropMask;
  end

  // ---------------- helpers ----------------
  task automatic wr(input logic [1:0] a, input logic [7:0] d);
    @(posedge clk); #2; wrEn = 1'b1; regAddr = a; wrData = d;
    @(posedge clk); #2; wrEn = 1'b0;
  endtask

  task automatic rd(input logic [1:0] a, output logic [7:0] v);
    @(posedge clk); #2; regAddr = a; #2; v = rdData;
  endtask

  task automatic cyclesWait(input int n);
    repeat (n) @(posedge clk);
  endtask

  task automatic waitGood(input string tag);
    int n;
    n = 0;
    while (!pwrGood && n < 200) begin @(posedge clk); #4; n++; end
    chk(tag, {4'd0, railEn}, 8'h0F);
  endtask

  task automatic summary();
    if (!finished) begin
      finished = 1;
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  endtask

  always @(posedge clk) begin
    cyc++;
    if (cyc > WDOG && !finished) begin
      failures++;
      $display("FAIL watchdog expired at cycle %0d: actual=running expected=done", cyc);
      summary();
    end
  end

  // ---------------- scenarios ----------------
  initial begin
    logic [7:0] v;
    cyclesWait(3);
    #2 rstN = 1'b1;

    // R1 reset state
    rd(2'd0, v); chk("R1 ctrl after reset", v, 8'h00);
    chk("R1 rails after reset", {4'd0, railEn}, 8'h00);
    rd(2'd2, v); chk("R1 fail after reset", v, 8'h00);
    rd(2'd3, v); chk("R1 version after reset", v, 8'h03);

    // R2, R3, R4 normal bring-up
    wr(2'd0, 8'hFF);
    rd(2'd0, v); chk("R2 enable readback", v, 8'h01);
    waitGood("R3 all rails on");
    rd(2'd1, v); chk("R4 status all good", v, 8'h0F);

    // R11 writes elsewhere are ignored
    wr(2'd3, 8'hFF); wr(2'd1, 8'hFF); wr(2'd2, 8'hFF);
    rd(2'd3, v); chk("R11 version after write", v, 8'h03);
    rd(2'd2, v); chk("R11 fail after write", v, 8'h00);
    rd(2'd1, v); chk("R11 status after write", v, 8'h0F);
    chk("R11 rails after write", {4'd0, railEn}, 8'h0F);

    // R8 disable then R9 immediate re-enable
    wr(2'd0, 8'h00);
    @(posedge clk); #4; chk("R8 rails off after disable", {4'd0, railEn}, 8'h00);
    wr(2'd0, 8'h01);
    for (int k = 0; k < H - 4; k++) begin
      @(posedge clk); #4; chk("R9 hold-off keeps rails off", {4'd0, railEn}, 8'h00);
    end
    waitGood("R9 bring-up resumes after hold-off");

    // R5 step timeout on rail 2, then R10 latch
    wr(2'd0, 8'h00); cyclesWait(H + 20);
    @(posedge clk); #2; stuck = 4'b0100;
    wr(2'd0, 8'h01);
    cyclesWait(100);
    chk("R5 rails off after timeout", {4'd0, railEn}, 8'h00);
    rd(2'd2, v); chk("R5 fail bit for rail 2", v, 8'h04);
    rd(2'd1, v); chk("R5 alarm bit set", v, 8'h10);
    wr(2'd0, 8'h01); cyclesWait(10);
    @(posedge clk); #4; chk("R10 fault stays, rails off", {4'd0, railEn}, 8'h00);
    rd(2'd2, v); chk("R10 fail still latched", v, 8'h04);
    wr(2'd0, 8'h00);
    rd(2'd2, v); chk("R8 fail cleared by disable", v, 8'h00);
    rd(2'd1, v); chk("R8 alarm cleared by disable", v & 8'h10, 8'h00);
    stuck = 4'b0000;
    cyclesWait(H + 20);

    // R6 alarm while fully on
    wr(2'd0, 8'h01);
    waitGood("R3 bring-up before alarm");
    @(posedge clk); #2; alarmIn = 1'b1;
    @(posedge clk); #2; alarmIn = 1'b0;
    #2; chk("R6 rails off after alarm", {4'd0, railEn}, 8'h00);
    rd(2'd1, v); chk("R6 alarm bit set", v & 8'h10, 8'h10);
    rd(2'd2, v); chk("R6 fail unchanged", v, 8'h00);
    wr(2'd0, 8'h00); cyclesWait(H + 20);

    // R6 alarm during ramp
    wr(2'd0, 8'h01);
    cyclesWait(2);
    @(posedge clk); #2; alarmIn = 1'b1;
    @(posedge clk); #2; alarmIn = 1'b0;
    #2; chk("R6 rails off after ramp alarm", {4'd0, railEn}, 8'h00);
    wr(2'd0, 8'h00); cyclesWait(H + 20);

    // R7 drop-out of rail 1 after bring-up
    wr(2'd0, 8'h01);
    waitGood("R3 bring-up before drop");
    @(posedge clk); #2; dropMask = 4'b0010;
    cyclesWait(3);
    rd(2'd2, v); chk("R7 fail bit for dropped rail", v, 8'h02);
    chk("R7 rails off after drop", {4'd0, railEn}, 8'h00);
    wr(2'd0, 8'h00);
    dropMask = 4'b0000;
    cyclesWait(H + 20);

    // rapid toggling does not wedge the sequence
    for (int k = 0; k < 4; k++) begin
      wr(2'd0, 8'h01); cyclesWait(k + 1); wr(2'd0, 8'h00);
    end
    wr(2'd0, 8'h01);
    waitGood("R9 bring-up after rapid toggling");
    wr(2'd0, 8'h00);
    cyclesWait(5);
    summary();
  end
endmodule